// File: doc/BRIEF.md
# EDO DRAM page-mode access sequencer

This block sits between a simple synchronous host port and an asynchronous 2M x 8 EDO DRAM. The host presents a 21-bit word address, a write flag and a byte of write data; the sequencer produces the row strobe, column strobe, write enable and output enable, multiplexes the row and column halves of the address onto an 11-bit address bus, drives write data, and returns read data with a one-cycle valid pulse.

After a row has been opened the row strobe stays low, and later requests to the same row are served as back-to-back EDO page cycles that only toggle the column strobe. The row is closed when a request targets another row, when the external refresh scheduler raises its request, or when the row strobe has been low long enough that one more page cycle could exceed the page-mode limit. Every analog timing limit is a parameter counted in whole clock cycles. Writes use early-write timing, so the DRAM never drives the data pins during a write. Refresh is handed over through a request/grant pair: the grant means all strobes are high and the precharge time has passed.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is asserted, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe`, `rd_valid` and `ref_gnt` are 0.
- R2: The row is `req_addr[20:10]` and the column is `req_addr[9:0]`. `dram_addr` carries the row on the edge where `dram_ras_n` falls, and `{1'b0, column}` on the edge where `dram_cas_n` falls.
- R3: The row strobe stays low for at least T_RAS cycles and high for at least T_RP cycles. Two falls of the row strobe are at least T_RC cycles apart. A fall of the column strobe comes at least T_RCD cycles after the fall of the row strobe.
- R4: The column strobe is low only while the row strobe is low. Each column-low pulse lasts at least T_CAS cycles. Within one row, the column strobe stays high for at least T_CP cycles, and two falls of the column strobe are at least T_HPC cycles apart.
- R5: A request whose row equals the open row is served with a column cycle alone, and the row strobe does not fall again.
- R6: A request to a different row first closes the open row, then opens the new row with exactly one fall of the row strobe.
- R7: A write is an early write. `dram_we_n` is 0 and `dram_dq_oe` is 1 on the edge where the column strobe falls, both hold for the whole column-low pulse, and `dram_oe_n` stays 1.
- R8: A read drives `dram_oe_n` to 0 only while the column strobe is low, and `dram_dq_oe` stays 0. The column-low pulse lasts at least max(T_CAC, T_AA) cycles, and the column strobe rises at least T_RAC cycles after the row strobe fell. `rd_valid` is high for exactly the one cycle that starts at the rise of the column strobe.
- R9: `rd_data` equals the byte most recently written to the same address.
- R10: While `ref_req` is 1, `req_ready` is 0. The open row is closed, and `ref_gnt` rises only when all strobes are high and the row strobe has been high for at least T_RP cycles.
- R11: The row strobe never stays low for T_RASP cycles. An open row with no traffic is closed on its own before that limit.
- R12: Each transfer with `req_valid` and `req_ready` both high produces exactly one column-strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (timing parameters are in cycles of it) |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address, row in bits 20:10, column in 9:0 |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse, `rd_data` holds read byte |
| rd_data | output | 8 | Read byte |
| ref_req | input | 1 | Refresh scheduler wants the DRAM |
| ref_gnt | output | 1 | DRAM released, strobes high, precharge met |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Write data toward DRAM |
| dram_dq_oe | output | 1 | Enable of the write data driver |
| dram_dq_in | input | 8 | Data from DRAM |

## Verification
The assertions assume that the host keeps `req_valid` and its request fields steady until `req_ready` accepts them, and that `ref_req` stays high until the grant has been used. The bench drives every request at the falling edge and holds it until the accepting edge. It raises the refresh request only after a transfer has completed, and drops it only after the grant has been seen. A behavioural DRAM model in the bench latches row and column on strobe falls, stores early-write data, returns stored bytes on reads, and measures every strobe interval against the timing parameters.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,   // row strobe high, precharging or waiting
    ST_RCD,    // row open, waiting for RAS-to-CAS delay
    ST_CASL,   // column strobe low, transfer in progress
    ST_PAGE    // row open, column strobe high
  } seq_state_t;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Column-low length of a read: the longest of the column-side limits.
  function automatic int unsigned rd_low_cycles(int unsigned t_cas, int unsigned t_cac,
                                                int unsigned t_aa);
    return umax(t_cas, umax(t_cac, t_aa));
  endfunction

  // Column-low length of a write: pulse width versus data hold.
  function automatic int unsigned wr_low_cycles(int unsigned t_cas, int unsigned t_dh);
    return umax(t_cas, t_dh);
  endfunction

  // Headroom that one more page cycle plus the closing edge can take.
  function automatic int unsigned page_guard(int unsigned rd_low, int unsigned wr_low,
                                             int unsigned t_cp);
    return umax(rd_low, wr_low) + t_cp + 2;
  endfunction

  // True when "age" cycles since an event, plus the coming edge, reach lim.
  function automatic logic reached(int unsigned age, int unsigned lim);
    return (age + 1) >= lim;
  endfunction

endpackage

// File: rtl/edo_age_cnt.sv
module edo_age_cnt #(
  parameter int W    = 14,
  parameter int MAXV = 10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] SAT = W'(MAXV);

  // Starts saturated so no limit is pending after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= SAT;
    else if (clr)        age <= '0;
    else if (age != SAT) age <= age + 1'b1;
  end
endmodule

// File: rtl/edo_row_match.sv
module edo_row_match #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_row,
  input  logic             close_row,
  input  logic [ROW_W-1:0] new_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else if (close_row) begin
      vld_q <= 1'b0;
    end else if (open_row) begin
      row_q <= new_row;
      vld_q <= 1'b1;
    end
  end

  assign hit = vld_q && (row_q == cmp_row);

  // R5: the sequencer never opens and closes a row on the same edge
  p_open_close_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_row && close_row));
  // R6: a freshly opened row matches the row it was opened for
  p_open_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    open_row |=> (vld_q && row_q == $past(new_row)));
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int DATA_W = 8,
  parameter int T_RAS  = 5,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 1,
  parameter int T_CP   = 1,
  parameter int T_HPC  = 2,
  parameter int T_RAC  = 5,
  parameter int T_CAC  = 2,
  parameter int T_AA   = 3,
  parameter int T_DH   = 1,
  parameter int T_RASP = 10000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     ref_req,
  output logic                     ref_gnt,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]        dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_in
);
  localparam int DA_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RD_LOW  = int'(rd_low_cycles(T_CAS, T_CAC, T_AA));
  localparam int WR_LOW  = int'(wr_low_cycles(T_CAS, T_DH));
  localparam int GUARD   = int'(page_guard(RD_LOW, WR_LOW, T_CP));
  localparam int CNT_MAX = int'(umax(T_RASP, umax(T_RC, T_RP)));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int NCNT    = 4;
  localparam int IX_RAS  = 0;  // since row strobe fell
  localparam int IX_PRE  = 1;  // since row strobe rose / refresh ended
  localparam int IX_CAS  = 2;  // since column strobe fell
  localparam int IX_CP   = 3;  // since column strobe rose

  seq_state_t         st;
  logic [COL_W-1:0]   pend_col;
  logic               cur_wr;
  logic [DATA_W-1:0]  pend_wd;
  logic [CW-1:0]      age [NCNT];
  logic [NCNT-1:0]    clr_vec;
  logic               hit;

  // Named internal events
  logic ev_ras_fall, ev_ras_rise, ev_cas_fall, ev_cas_rise, ev_ref_end;
  logic can_open, must_close, close_now, page_go, rcd_go, cas_done;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  int unsigned      low_need;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  assign can_open  = (st == ST_IDLE) && !ref_req && !ref_gnt
                     && reached(int'(age[IX_PRE]), T_RP)
                     && reached(int'(age[IX_RAS]), T_RC);
  assign must_close = (st == ST_PAGE) &&
                      (ref_req || (req_valid && !hit) ||
                       (int'(age[IX_RAS]) + 1 + GUARD >= T_RASP));
  assign close_now = must_close && reached(int'(age[IX_RAS]), T_RAS);
  assign page_go   = (st == ST_PAGE) && !must_close && hit
                     && reached(int'(age[IX_CP]), T_CP)
                     && reached(int'(age[IX_CAS]), T_HPC);
  assign rcd_go    = (st == ST_RCD) && reached(int'(age[IX_RAS]), T_RCD);
  assign low_need  = cur_wr ? WR_LOW : RD_LOW;
  assign cas_done  = (st == ST_CASL) && reached(int'(age[IX_CAS]), low_need)
                     && (cur_wr || reached(int'(age[IX_RAS]), T_RAC));

  assign req_ready   = can_open || page_go;
  assign ev_ras_fall = can_open && req_valid;
  assign ev_ras_rise = close_now;
  assign ev_cas_fall = rcd_go || (page_go && req_valid);
  assign ev_cas_rise = cas_done;
  assign ev_ref_end  = ref_gnt && !ref_req;

  assign clr_vec[IX_RAS] = ev_ras_fall;
  assign clr_vec[IX_PRE] = ev_ras_rise || ev_ref_end;
  assign clr_vec[IX_CAS] = ev_cas_fall;
  assign clr_vec[IX_CP]  = ev_cas_rise;

  for (genvar g = 0; g < NCNT; g++) begin : g_age
    edo_age_cnt #(.W(CW), .MAXV(CNT_MAX)) u_age (
      .clk(clk), .rst_n(rst_n), .clr(clr_vec[g]), .age(age[g])
    );
  end

  edo_row_match #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .open_row(ev_ras_fall), .close_row(ev_ras_rise),
    .new_row(req_row), .cmp_row(req_row), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_dq_oe  <= 1'b0;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      ref_gnt     <= 1'b0;
      pend_col    <= '0;
      pend_wd     <= '0;
      cur_wr      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          ref_gnt <= ref_req && reached(int'(age[IX_PRE]), T_RP);
          if (ev_ras_fall) begin
            dram_ras_n <= 1'b0;
            dram_addr  <= DA_W'(req_row);
            pend_col   <= req_col;
            pend_wd    <= req_wdata;
            cur_wr     <= req_write;
            st         <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (rcd_go) begin
            dram_cas_n  <= 1'b0;
            dram_addr   <= DA_W'(pend_col);
            dram_we_n   <= !cur_wr;
            dram_oe_n   <= cur_wr;
            dram_dq_oe  <= cur_wr;
            dram_dq_out <= pend_wd;
            st          <= ST_CASL;
          end
        end
        ST_CASL: begin
          if (cas_done) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            if (!cur_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
            st <= ST_PAGE;
          end
        end
        ST_PAGE: begin
          if (close_now) begin
            dram_ras_n <= 1'b1;
            st         <= ST_IDLE;
          end else if (page_go && req_valid) begin
            dram_cas_n  <= 1'b0;
            dram_addr   <= DA_W'(req_col);
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            cur_wr      <= req_write;
            st          <= ST_CASL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: column strobe low only inside an open row
  p_cas_in_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R7: early write, data driven and output enable high at the column fall
  p_early_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> (dram_oe_n && dram_dq_oe));
  // R7: write enable only during a column-low pulse with data driven
  p_we_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> (!dram_cas_n && dram_dq_oe));
  // R8: output enable never overlaps the write driver
  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_oe_n |-> (!dram_dq_oe && dram_we_n && !dram_cas_n));
  // R8: read valid is a single pulse aligned with the column rise
  p_rdv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_rdv_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(dram_cas_n));
  // R10: grant only with the DRAM quiet and no host acceptance
  p_gnt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));
  p_ref_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !req_ready);
  // R11: the row strobe low time stays under the page-mode limit
  p_rasp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (int'(age[IX_RAS]) < T_RASP));
endmodule

// File: tb/test_edo_page_ctrl.sv
module test_edo_page_ctrl;
  localparam int T_RAS = 5, T_RP = 3, T_RC = 9, T_RCD = 2, T_CAS = 1, T_CP = 1;
  localparam int T_HPC = 2, T_RAC = 5, T_CAC = 2, T_AA = 3, T_DH = 1, T_RASP = 10000;
  localparam int RD_MIN = (T_CAC > T_AA) ? T_CAC : T_AA;

  typedef struct packed {
    logic        wr;
    logic [20:0] addr;
    logic [7:0]  data;
    logic        miss;
  } vec_t;

  // write flag, address, data (write) , expect a new row opening
  localparam vec_t VECS [12] = '{
    '{1'b1, 21'h000005, 8'h11, 1'b1},
    '{1'b1, 21'h000006, 8'h22, 1'b0},
    '{1'b0, 21'h000005, 8'h00, 1'b0},
    '{1'b0, 21'h000006, 8'h00, 1'b0},
    '{1'b1, 21'h1FFFFF, 8'h7E, 1'b1},
    '{1'b0, 21'h1FFFFF, 8'h00, 1'b0},
    '{1'b1, 21'h1FFC00, 8'h3C, 1'b0},
    '{1'b0, 21'h000005, 8'h00, 1'b1},
    '{1'b1, 21'h0AB3C1, 8'hC3, 1'b1},
    '{1'b1, 21'h0AB3C1, 8'h5A, 1'b0},
    '{1'b0, 21'h0AB3C1, 8'h00, 1'b0},
    '{1'b0, 21'h1FFC00, 8'h00, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dram_dq_in = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [7:0]  rd_data, dram_dq_out;
  logic [10:0] dram_addr;

  always #4 clk = ~clk;

  edo_page_ctrl i_edo_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- DRAM model and timing monitor ----------------
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];
  logic prev_ras = 1'b1, prev_cas = 1'b1, m_wr = 1'b0, first_in_row = 1'b1;
  logic [10:0] m_row = '0;
  logic [9:0]  m_col = '0;
  int ras_lo = 0, ras_hi = 1000, since_ras = 1000, cas_lo = 0, cas_hi = 1000;
  int since_cas = 1000, ras_falls = 0, cas_rises = 0, max_ras_lo = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_ras++;
      since_cas++;
      if (!dram_oe_n) chk(!dram_dq_oe, "R8 oe vs dq_oe", dram_dq_oe, 0);
      // row strobe
      if (prev_ras && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R3 precharge", ras_hi, T_RP);
        chk(since_ras >= T_RC, "R3 row cycle", since_ras, T_RC);
        m_row = dram_addr;
        ras_falls++;
        since_ras = 0;
        ras_lo = 1;
        first_in_row = 1'b1;
      end else if (!prev_ras && dram_ras_n) begin
        chk(ras_lo >= T_RAS, "R3 row low width", ras_lo, T_RAS);
        ras_hi = 1;
      end else if (!dram_ras_n) ras_lo++;
      else ras_hi++;
      if (ras_lo > max_ras_lo) max_ras_lo = ras_lo;
      // column strobe
      if (prev_cas && !dram_cas_n) begin
        chk(!dram_ras_n, "R4 cas inside row", dram_ras_n, 0);
        chk(since_ras >= T_RCD, "R3 ras to cas", since_ras, T_RCD);
        if (!first_in_row) begin
          chk(since_cas >= T_HPC, "R4 page spacing", since_cas, T_HPC);
          chk(cas_hi >= T_CP, "R4 cas precharge", cas_hi, T_CP);
        end
        chk(dram_addr[10] == 1'b0, "R2 column bit10", dram_addr[10], 0);
        m_col = dram_addr[9:0];
        m_wr = !dram_we_n;
        first_in_row = 1'b0;
        since_cas = 0;
        cas_lo = 1;
        if (m_wr) begin
          chk(dram_oe_n && dram_dq_oe, "R7 early write", {dram_oe_n, dram_dq_oe}, 2'b11);
          mem[{m_row, m_col}] = dram_dq_out;
        end else begin
          dram_dq_in = mem.exists({m_row, m_col}) ? mem[{m_row, m_col}] : 8'hA5;
          chk(!dram_dq_oe, "R8 no drive on read", dram_dq_oe, 0);
        end
      end else if (!prev_cas && dram_cas_n) begin
        chk(cas_lo >= T_CAS, "R4 cas width", cas_lo, T_CAS);
        if (!m_wr) begin
          chk(cas_lo >= RD_MIN, "R8 column access", cas_lo, RD_MIN);
          chk(since_ras >= T_RAC, "R8 row access", since_ras, T_RAC);
        end
        cas_hi = 1;
        cas_rises++;
      end else if (!dram_cas_n) begin
        cas_lo++;
        if (m_wr) chk(dram_dq_oe && !dram_we_n && dram_oe_n, "R7 write hold",
                      {dram_dq_oe, dram_we_n, dram_oe_n}, 3'b101);
      end else cas_hi++;
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
    end
  end

  // ---------------- host request task ----------------
  task automatic do_req(input vec_t v, input string tag);
    int rf0, cr0, waitn;
    bit got;
    logic [7:0] rdat, expd;
    rf0 = ras_falls;
    cr0 = cas_rises;
    got = 0;
    rdat = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
    #1;
    waitn = 0;
    while (!req_ready && waitn < 200) begin
      @(negedge clk); #1; waitn++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    waitn = 0;
    while (cas_rises == cr0 && waitn < 200) begin
      if (rd_valid) begin got = 1; rdat = rd_data; end
      if (cas_rises != cr0) break;
      @(negedge clk); #2; waitn++;
    end
    if (rd_valid) begin got = 1; rdat = rd_data; end
    chk(cas_rises - cr0 == 1, {"R12 one column cycle ", tag}, cas_rises - cr0, 1);
    chk(ras_falls - rf0 == int'(v.miss), {v.miss ? "R6 miss opens row " : "R5 hit keeps row ", tag},
        ras_falls - rf0, v.miss);
    chk(m_row == v.addr[20:10] && m_col == v.addr[9:0], {"R2 address mux ", tag},
        {m_row, m_col}, v.addr);
    if (v.wr) exp_mem[v.addr] = v.data;
    else begin
      expd = exp_mem.exists(v.addr) ? exp_mem[v.addr] : 8'hA5;
      chk(got, {"R8 read valid pulse ", tag}, got, 1);
      chk(rdat == expd, {"R9 read data ", tag}, rdat, expd);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int waitn, rf0, gwait;
    vec_t v;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
    chk({dram_dq_oe, rd_valid, ref_gnt} == 3'b000, "R1 outputs in reset",
        {dram_dq_oe, rd_valid, ref_gnt}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk
    for (int i = 0; i < 12; i++) begin
      do_req(VECS[i], $sformatf("vec%0d", i));
    end

    // R10 refresh handover with a row open
    @(negedge clk);
    ref_req = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 21'h1FFC00;
    #1;
    chk(!req_ready, "R10 ready blocked by refresh", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    waitn = 0;
    while (!ref_gnt && waitn < 100) begin @(negedge clk); waitn++; end
    #2;
    chk(ref_gnt, "R10 grant arrives", ref_gnt, 1);
    chk(dram_ras_n && dram_cas_n, "R10 quiet at grant", {dram_ras_n, dram_cas_n}, 2'b11);
    chk(ras_hi >= T_RP, "R10 precharge before grant", ras_hi, T_RP);
    gwait = 0;
    repeat (4) begin
      @(negedge clk); #1;
      if (!ref_gnt || req_ready) gwait++;
    end
    chk(gwait == 0, "R10 grant held, ready low", gwait, 0);
    ref_req = 1'b0;
    v = '{1'b0, 21'h1FFC00, 8'h00, 1'b1};
    do_req(v, "after refresh");

    // R11 idle open row closes on its own
    rf0 = ras_falls;
    waitn = 0;
    while (!dram_ras_n && waitn < T_RASP + 100) begin @(negedge clk); waitn++; end
    #2;
    chk(dram_ras_n, "R11 idle row closed", dram_ras_n, 1);
    chk(max_ras_lo < T_RASP, "R11 row low limit", max_ras_lo, T_RASP);
    chk(ras_falls == rf0, "R11 no reopen", ras_falls, rf0);
    // a hit on the former row now needs a fresh opening
    v = '{1'b0, 21'h1FFFFF, 8'h00, 1'b1};
    do_req(v, "after timeout");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule